// File: doc/BRIEF.md
# Dual-Mode Image Buffer Address Generator

This block computes addresses for a single image buffer of 2^ADDR_W locations. The buffer is nominally one million locations. The block lays that buffer out in one of two ways. In calibration mode the buffer is a grid with 2^PIX_W pixels per line and 2^LINE_W lines. Raw scan data is written into it line after line. A column reader returns one pixel position from a run of successive lines, so that a controller can average that pixel over time.

In scanning mode the first sixteenth of the buffer is a scratch line used by a 3/4 shrink stage. The other fifteen sixteenths are three equal circular regions, one for each colour. Each region holds a whole number of scan lines of SCAN_LEN locations. For each colour, a read pointer trails the write pointer by a programmable number of lines, and this realigns the colour channels in time.

One request port serves every access. Each accepted request produces one registered address on the memory side. Mode changes wait until every active stream stands at the start of a line, and they clear all pointers.

Top module: `lbag_top`

## Requirements
- R1: After reset the mode is calibration (mode_o = 0), mem_vld is 0, and the first calibration write addresses location 0.
- R2: A calibration write (req_wr = 1, mode_o = 0) addresses {line, pixel}, with the line in the upper LINE_W bits and the pixel in the lower PIX_W bits. Successive writes therefore step the address by one, and the address wraps from 2^ADDR_W-1 to 0.
- R3: In calibration mode, col_load sets the column pointer to {col_line, col_pix}. Each column read (req_wr = 0) returns the current {line, pixel} and then advances the line by one, wrapping at 2^LINE_W. The pixel does not change.
- R4: An accepted request appears on the clock edge that accepts it. From then until the next edge, mem_vld is 1, mem_we equals req_wr and mem_addr holds its address. In every other cycle mem_vld is 0.
- R5: A change of mode_req takes effect only when every active stream is at pixel 0 of a line. In calibration mode that means the write stream. In scanning mode it means all four write streams and all four read streams. Until then the mode is held.
- R6: A mode change returns every write pointer and the column pointer to line 0, pixel 0.
- R7: In scanning mode, req_chan 3 selects the scratch region, which starts at 0. req_chan c = 0, 1 or 2 selects colour region c, based at 2^ADDR_W/16 + c*REG. REG is floor(2^ADDR_W*15/48 / SCAN_LEN) * SCAN_LEN.
- R8: A colour write addresses base + line*SCAN_LEN + pixel. The pixel wraps at SCAN_LEN into the next line, and the line wraps at REG/SCAN_LEN, so the region is circular.
- R9: On entry to scanning mode, colour c's read pointer starts at line (NLINES - d) mod NLINES, pixel 0. Here d is field c of dly_cfg (bits c*DLY_W upward), d < NLINES, and NLINES = REG/SCAN_LEN. After that it advances like a write pointer.
- R10: The scratch write and read pointers each step through locations 0 to SCAN_LEN-1 and wrap back to 0.
- R11: A request is dropped (mem_vld stays 0 and no pointer moves) when it arrives in the same cycle as a mode change, or with col_load in calibration mode. In scanning mode col_load is ignored.
- R12: A request moves only the pointer of its own channel and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 1 | Requested mode: 0 calibration, 1 scanning |
| mode_o | output | 1 | Mode in force |
| req_stb | input | 1 | Access request |
| req_wr | input | 1 | 1 write, 0 read |
| req_chan | input | 2 | Scanning channel: 0 to 2 colour, 3 scratch |
| col_load | input | 1 | Load the column pointer (calibration) |
| col_pix | input | PIX_W | Column pixel to load |
| col_line | input | LINE_W | Starting line to load |
| dly_cfg | input | 3*DLY_W | Read lag in lines for each colour |
| mem_vld | output | 1 | Address valid |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Buffer address |

## Verification
The hardest situation to reach is a mode change while streams are in the middle of a line. In that case the pending request must survive until the last of eight pointers reaches a line start, and a request that coincides with the switch must vanish. The bench keeps its own per-stream access counts. It raises mode_req while a pointer is off its boundary and confirms the mode holds. It then tops up each stream to a line end and places a request exactly on the switching edge. It also runs a colour ring and the whole calibration grid through a full wrap.

// File: rtl/lbag_pkg.sv
package lbag_pkg;
   typedef enum logic {
      MODE_CAL  = 1'b0,
      MODE_SCAN = 1'b1
   } lbag_mode_e;

   localparam logic [1:0] CH_SCRATCH = 2'd3;
endpackage

// File: rtl/lbag_lp_ctr.sv
// Pixel/line pointer; generate picks natural or compared wrap per field.
module lbag_lp_ctr #(
   parameter int unsigned PIX_LEN = 64,
   parameter int unsigned LINES   = 4,
   parameter int unsigned PXW     = 6,
   parameter int unsigned LNW     = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic [LNW-1:0] init_line,
   input  logic           step,
   output logic [PXW-1:0] pix,
   output logic [LNW-1:0] line
);
   logic           pix_last;
   logic [PXW-1:0] pix_nx;
   logic [LNW-1:0] line_nx;

   if (PIX_LEN < 2 || PIX_LEN > (1 << PXW)) begin : g_bad_pix
      $error("lbag_lp_ctr: PIX_LEN out of range");
   end
   if (LINES < 1 || LINES > (1 << LNW)) begin : g_bad_line
      $error("lbag_lp_ctr: LINES out of range");
   end

   if (PIX_LEN == (1 << PXW)) begin : g_pix_pow2
      assign pix_last = &pix;
      assign pix_nx   = pix + PXW'(1);
   end else begin : g_pix_cmp
      assign pix_last = (pix == PXW'(PIX_LEN - 1));
      assign pix_nx   = pix_last ? '0 : pix + PXW'(1);
   end

   if (LINES == 1) begin : g_line_one
      assign line_nx = '0;
   end else if (LINES == (1 << LNW)) begin : g_line_pow2
      assign line_nx = line + LNW'(1);
   end else begin : g_line_cmp
      assign line_nx = (line == LNW'(LINES - 1)) ? '0 : line + LNW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix  <= '0;
         line <= '0;
      end else if (clr) begin
         pix  <= '0;
         line <= init_line;
      end else if (step) begin
         pix <= pix_nx;
         if (pix_last) line <= line_nx;
      end
   end
endmodule

// File: rtl/lbag_cal_unit.sv
// Calibration layout: raster write stream plus column reader.
module lbag_cal_unit #(
   parameter int unsigned PIX_W  = 12,
   parameter int unsigned LINE_W = 8,
   localparam int unsigned AW    = PIX_W + LINE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_step,
   input  logic              rd_step,
   input  logic              col_load,
   input  logic [PIX_W-1:0]  col_pix,
   input  logic [LINE_W-1:0] col_line,
   input  logic              sel_wr,
   output logic [AW-1:0]     addr,
   output logic              at_gap
);
   logic [PIX_W-1:0]  w_pix;
   logic [LINE_W-1:0] w_line;
   logic [PIX_W-1:0]  c_pix;
   logic [LINE_W-1:0] c_line;

   lbag_lp_ctr #(
      .PIX_LEN (1 << PIX_W),
      .LINES   (1 << LINE_W),
      .PXW     (PIX_W),
      .LNW     (LINE_W)
   ) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .init_line ('0),
      .step      (wr_step),
      .pix       (w_pix),
      .line      (w_line)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         c_pix  <= '0;
         c_line <= '0;
      end else if (col_load) begin
         c_pix  <= col_pix;
         c_line <= col_line;
      end else if (rd_step) begin
         c_line <= c_line + LINE_W'(1);
      end
   end

   assign addr   = sel_wr ? {w_line, w_pix} : {c_line, c_pix};
   assign at_gap = (w_pix == '0);
endmodule

// File: rtl/lbag_scan_unit.sv
// Scanning layout: scratch line plus three circular colour regions.
module lbag_scan_unit #(
   parameter int unsigned ADDR_W   = 20,
   parameter int unsigned SCAN_LEN = 4096,
   parameter int unsigned DLY_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 step,
   input  logic                 sel_wr,
   input  logic [1:0]           chan,
   input  logic [3*DLY_W-1:0]   dly,
   output logic [ADDR_W-1:0]    addr,
   output logic                 at_gap
);
   import lbag_pkg::*;

   localparam int unsigned TOT      = 1 << ADDR_W;
   localparam int unsigned SCR_LOCS = TOT / 16;
   localparam int unsigned NLINES   = (SCR_LOCS * 5) / SCAN_LEN;
   localparam int unsigned REG_LOCS = NLINES * SCAN_LEN;
   localparam int unsigned PXW      = $clog2(SCAN_LEN);
   localparam int unsigned LNW      = $clog2(NLINES);

   if (SCAN_LEN < 2 || SCAN_LEN > SCR_LOCS) begin : g_bad_len
      $error("lbag_scan_unit: SCAN_LEN must fit the scratch sixteenth");
   end
   if (NLINES < 2) begin : g_bad_lines
      $error("lbag_scan_unit: colour region holds fewer than two lines");
   end

   logic [PXW-1:0] wpix  [4];
   logic [LNW-1:0] wline [4];
   logic [PXW-1:0] rpix  [4];
   logic [LNW-1:0] rline [4];

   for (genvar c = 0; c < 4; c++) begin : g_ch
      localparam int unsigned C_LINES = (c == 3) ? 1 : NLINES;
      logic [LNW-1:0] rinit;
      logic           hit;

      assign hit = step && (chan == 2'(c));

      if (c == 3) begin : g_scr
         assign rinit = '0;
      end else begin : g_col
         logic [DLY_W-1:0] d;
         assign d     = dly[c*DLY_W +: DLY_W];
         assign rinit = (d == '0) ? '0 : LNW'(NLINES - int'(d));
      end

      lbag_lp_ctr #(.PIX_LEN(SCAN_LEN), .LINES(C_LINES), .PXW(PXW), .LNW(LNW)) u_w (
         .clk(clk), .rst_n(rst_n), .clr(clr), .init_line('0),
         .step(hit && sel_wr), .pix(wpix[c]), .line(wline[c])
      );
      lbag_lp_ctr #(.PIX_LEN(SCAN_LEN), .LINES(C_LINES), .PXW(PXW), .LNW(LNW)) u_r (
         .clk(clk), .rst_n(rst_n), .clr(clr), .init_line(rinit),
         .step(hit && !sel_wr), .pix(rpix[c]), .line(rline[c])
      );
   end

   logic [ADDR_W-1:0] base;
   logic [LNW-1:0]    ln;
   logic [PXW-1:0]    px;

   always_comb begin
      base = (chan == CH_SCRATCH) ? '0
           : ADDR_W'(SCR_LOCS) + ADDR_W'(chan) * ADDR_W'(REG_LOCS);
      ln   = sel_wr ? wline[chan] : rline[chan];
      px   = sel_wr ? wpix[chan]  : rpix[chan];
      addr = base + ADDR_W'(ln) * ADDR_W'(SCAN_LEN) + ADDR_W'(px);
   end

   always_comb begin
      at_gap = 1'b1;
      for (int c = 0; c < 4; c++) begin
         if (wpix[c] != '0 || rpix[c] != '0) at_gap = 1'b0;
      end
   end
endmodule

// File: rtl/lbag_top.sv
module lbag_top #(
   parameter int unsigned ADDR_W   = 20,
   parameter int unsigned PIX_W    = 12,
   parameter int unsigned LINE_W   = 8,
   parameter int unsigned SCAN_LEN = 4096,
   parameter int unsigned DLY_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mode_req,
   output logic                mode_o,
   input  logic                req_stb,
   input  logic                req_wr,
   input  logic [1:0]          req_chan,
   input  logic                col_load,
   input  logic [PIX_W-1:0]    col_pix,
   input  logic [LINE_W-1:0]   col_line,
   input  logic [3*DLY_W-1:0]  dly_cfg,
   output logic                mem_vld,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr
);
   import lbag_pkg::*;

   if (ADDR_W != PIX_W + LINE_W) begin : g_bad_split
      $error("lbag_top: ADDR_W must equal PIX_W + LINE_W");
   end
   if (ADDR_W < 8 || ADDR_W > 30) begin : g_bad_aw
      $error("lbag_top: ADDR_W out of range");
   end

   lbag_mode_e        mode_q;
   logic              cal_gap, scan_gap, all_gap;
   logic              is_cal, switch_now, acc;
   logic [ADDR_W-1:0] cal_addr, scan_addr;

   assign is_cal     = (mode_q == MODE_CAL);
   assign all_gap    = is_cal ? cal_gap : scan_gap;
   assign switch_now = (mode_req != mode_q) && all_gap;
   assign acc        = req_stb && !switch_now && !(col_load && is_cal);

   lbag_cal_unit #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (switch_now),
      .wr_step  (acc && is_cal && req_wr),
      .rd_step  (acc && is_cal && !req_wr),
      .col_load (col_load && is_cal && !switch_now),
      .col_pix  (col_pix),
      .col_line (col_line),
      .sel_wr   (req_wr),
      .addr     (cal_addr),
      .at_gap   (cal_gap)
   );

   lbag_scan_unit #(.ADDR_W(ADDR_W), .SCAN_LEN(SCAN_LEN), .DLY_W(DLY_W)) u_scan (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (switch_now),
      .step   (acc && !is_cal),
      .sel_wr (req_wr),
      .chan   (req_chan),
      .dly    (dly_cfg),
      .addr   (scan_addr),
      .at_gap (scan_gap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MODE_CAL;
         mem_vld  <= 1'b0;
         mem_we   <= 1'b0;
         mem_addr <= '0;
      end else begin
         if (switch_now) mode_q <= lbag_mode_e'(mode_req);
         mem_vld <= acc;
         if (acc) begin
            mem_we   <= req_wr;
            mem_addr <= is_cal ? cal_addr : scan_addr;
         end
      end
   end

   assign mode_o = mode_q;
endmodule

// File: rtl/lbag_chk.sv
module lbag_chk #(
   parameter int unsigned ADDR_W   = 20,
   parameter int unsigned PIX_W    = 12,
   parameter int unsigned SCAN_LEN = 4096
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_o,
   input logic              req_stb,
   input logic              req_wr,
   input logic [1:0]        req_chan,
   input logic              mem_vld,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              all_gap
);
   localparam longint SIXTEENTH = (longint'(1) << ADDR_W) / 16;
   localparam longint RING      = ((SIXTEENTH * 5) / SCAN_LEN) * SCAN_LEN;
   localparam int unsigned LINE_W = ADDR_W - PIX_W;

   logic [1:0] ch_q;
   always_ff @(posedge clk) ch_q <= req_chan;

   p_switch_at_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != $past(mode_o)) |-> $past(all_gap));

   p_out_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_vld |-> ($past(req_stb) && mem_we == $past(req_wr)));

   p_cal_raster_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_vld && mem_we && !mode_o && $past(mem_vld && mem_we && !mode_o))
      |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

   p_col_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_vld && !mem_we && !mode_o && $past(mem_vld && !mem_we && !mode_o))
      |-> (mem_addr[ADDR_W-1:PIX_W] == $past(mem_addr[ADDR_W-1:PIX_W]) + LINE_W'(1)
           && mem_addr[PIX_W-1:0] == $past(mem_addr[PIX_W-1:0])));

   p_colour_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_vld && mode_o && ch_q != 2'd3)
      |-> (longint'(mem_addr) >= SIXTEENTH + longint'(ch_q) * RING
           && longint'(mem_addr) < SIXTEENTH + (longint'(ch_q) + 1) * RING));

   p_scratch_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_vld && mode_o && ch_q == 2'd3) |-> (longint'(mem_addr) < longint'(SCAN_LEN)));
endmodule

bind lbag_top lbag_chk #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .SCAN_LEN(SCAN_LEN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_o   (mode_o),
   .req_stb  (req_stb),
   .req_wr   (req_wr),
   .req_chan (req_chan),
   .mem_vld  (mem_vld),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .all_gap  (all_gap)
);

// File: tb/sim_lbag_top.sv
module sim_lbag_top;
   localparam int AW = 12, PW = 6, LW = 6, SL = 64, DW = 5;
   localparam int SCR = 256, REG = 1280, NL = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_req = 1'b0;
   logic          mode_o;
   logic          req_stb = 1'b0;
   logic          req_wr = 1'b0;
   logic [1:0]    req_chan = '0;
   logic          col_load = 1'b0;
   logic [PW-1:0] col_pix = '0;
   logic [LW-1:0] col_line = '0;
   logic [3*DW-1:0] dly_cfg = '0;
   logic          mem_vld, mem_we;
   logic [AW-1:0] mem_addr;

   int n_chk = 0, n_fail = 0;
   int wcnt [4];
   int rcnt [4];
   bit done = 0;

   always #2 clk = ~clk;

   lbag_top #(.ADDR_W(AW), .PIX_W(PW), .LINE_W(LW), .SCAN_LEN(SL), .DLY_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_o(mode_o),
      .req_stb(req_stb), .req_wr(req_wr), .req_chan(req_chan),
      .col_load(col_load), .col_pix(col_pix), .col_line(col_line),
      .dly_cfg(dly_cfg), .mem_vld(mem_vld), .mem_we(mem_we), .mem_addr(mem_addr)
   );

   task automatic chk(string tag, longint act, longint exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic go(bit wr, int ch);
      req_stb  = 1'b1;
      req_wr   = wr;
      req_chan = 2'(ch);
      @(negedge clk);
      if (mode_o) begin
         if (wr) wcnt[ch]++; else rcnt[ch]++;
      end
   endtask

   task automatic idle(int n);
      req_stb = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 mode after reset", mode_o, 0);
      chk("R1 vld after reset", mem_vld, 0);
      go(1, 0);
      chk("R1 first write addr", mem_addr, 0);
      chk("R4 vld", mem_vld, 1);
      chk("R4 we", mem_we, 1);
   endtask

   task automatic t_cal_write;
      for (int k = 1; k <= 4096; k++) begin
         go(1, 0);
         chk("R2 raster addr", mem_addr, k % 4096);
      end
      idle(1);
      chk("R4 idle vld", mem_vld, 0);
   endtask

   task automatic t_col_read;
      int lines [4] = '{62, 63, 0, 1};
      col_pix = 6'd5; col_line = 6'd62; col_load = 1'b1;
      idle(1);
      col_load = 1'b0;
      for (int k = 0; k < 4; k++) begin
         go(0, 0);
         chk("R3 column addr", mem_addr, lines[k] * 64 + 5);
         chk("R4 read we", mem_we, 0);
      end
      col_pix = 6'd9; col_line = 6'd10; col_load = 1'b1;
      go(0, 0);
      chk("R11 drop with col_load", mem_vld, 0);
      col_load = 1'b0;
      go(0, 0);
      chk("R11 load took effect", mem_addr, 10 * 64 + 9);
      idle(1);
   endtask

   task automatic t_mode_pending;
      dly_cfg  = {5'd19, 5'd3, 5'd0};
      mode_req = 1'b1;
      idle(3);
      chk("R5 held off line start", mode_o, 0);
      for (int k = 1; k <= 63; k++) begin
         go(1, 0);
         chk("R2 raster addr", mem_addr, k);
      end
      idle(1);
      chk("R5 switched at line start", mode_o, 1);
   endtask

   task automatic t_scan_write;
      go(1, 0); chk("R7 colour0 base", mem_addr, SCR);
      go(1, 1); chk("R7 colour1 base", mem_addr, SCR + REG);
      go(1, 2); chk("R7 colour2 base", mem_addr, SCR + 2 * REG);
      go(1, 3); chk("R7 scratch base", mem_addr, 0);
      for (int k = 1; k <= REG; k++) begin
         go(1, 0);
         chk("R8 ring addr", mem_addr, SCR + (k % REG));
      end
      go(1, 1); chk("R12 colour1 untouched", mem_addr, SCR + REG + 1);
   endtask

   task automatic t_scan_read;
      go(0, 0); chk("R9 colour0 lag 0", mem_addr, SCR);
      col_load = 1'b1;
      go(0, 0); chk("R11 col_load ignored in scan", mem_addr, SCR + 1);
      col_load = 1'b0;
      go(0, 1); chk("R9 colour1 lag 3", mem_addr, SCR + REG + 17 * SL);
      for (int k = 1; k <= 63; k++) go(0, 1);
      go(0, 1); chk("R9 colour1 next line", mem_addr, SCR + REG + 18 * SL);
      go(0, 2); chk("R9 colour2 lag 19", mem_addr, SCR + 2 * REG + SL);
      go(0, 2); chk("R12 colour2 own pointer", mem_addr, SCR + 2 * REG + SL + 1);
   endtask

   task automatic t_scratch;
      for (int k = 1; k <= 64; k++) begin
         go(1, 3);
         chk("R10 scratch write", mem_addr, k % 64);
      end
      go(0, 3); chk("R10 scratch read", mem_addr, 0);
      go(0, 3); chk("R10 scratch read", mem_addr, 1);
   endtask

   task automatic t_return;
      mode_req = 1'b0;
      idle(2);
      chk("R5 scan held mid line", mode_o, 1);
      for (int ch = 0; ch < 4; ch++) begin
         int nw = (64 - wcnt[ch] % 64) % 64;
         int nr = (64 - rcnt[ch] % 64) % 64;
         for (int k = 0; k < nw; k++) go(1, ch);
         for (int k = 0; k < nr; k++) go(0, ch);
      end
      go(1, 0);
      chk("R11 drop on switch edge", mem_vld, 0);
      chk("R5 back to calibration", mode_o, 0);
      go(1, 0); chk("R6 write pointer cleared", mem_addr, 0);
      go(0, 0); chk("R6 column pointer cleared", mem_addr, 0);
      idle(1);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin wcnt[i] = 0; rcnt[i] = 0; end
      @(negedge clk);
      t_reset();
      t_cal_write();
      t_col_read();
      t_mode_pending();
      t_scan_write();
      t_scan_read();
      t_scratch();
      t_return();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #800000;
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule